// File: doc/BRIEF.md
# Disk Task-File Register Bank

This block is the register file that a host sees on a disk-style device interface. The host reaches it through a two-bit register select with separate read and write strobes. Behind the select sit a status byte, which can be read in two ways, a command byte and two address bytes. Each address byte is two entries deep. Every accepted host write to an address byte moves the current entry into a "previous" entry, so the host can load a 48-bit LBA with two writes per byte. A control bit in the device-control register decides whether host reads of the address bytes return the current entries or the previous ones.

The host starts a command by writing the command byte. The block then sets BSY, drops any pending interrupt and gives the device-side engine a one-cycle start pulse. With that pulse come the latched command code and all four address entries. When the engine finishes, it sends a one-cycle completion strobe with a new status byte and new address contents, and the block raises its interrupt. A read of the primary status register acknowledges the interrupt. A read of the alternate status register returns the same byte and leaves the interrupt untouched.

Top module: `tf_regbank`

## Requirements
- R1: After reset the status byte reads 8'h40, irq and cmd_start are low, all four address entries read zero, and the high-order select bit is clear.
- R2: Status bits are bit7 BSY, bit6 RDY, bit5 device fault, bit4 seek-complete/service, bit3 DRQ, bit2 corrected, bit1 index, bit0 error. Select 2 reads back the status byte exactly as it is held. An accepted command write sets bit7 and leaves the other seven bits unchanged.
- R3: A read at select 3 (alternate status) returns the same byte as select 2 and never clears a pending interrupt.
- R4: A read at select 2 clears irq from the next cycle. If an engine completion arrives in the same cycle as that read, irq stays set.
- R5: A write at select 2 while BSY is clear is an accepted command write. cmd_start is high for exactly the next cycle, and cmd_code then holds the written byte.
- R6: While cmd_start is high, cmd_addr equals {prev high, prev low, current high, current low}. These entries map to LBA bits 47:40, 39:32, 23:16 and 15:8.
- R7: An accepted write at select 0 (low address byte) or select 1 (high address byte) moves that byte's current entry into its previous entry and stores the written data as the current entry.
- R8: A write at select 3 loads the high-order select bit from data bit 7. While that bit is set, reads at select 0/1 return the previous entries. An accepted write at select 0, 1 or 2 clears the bit.
- R9: An engine completion strobe loads the status byte from eng_status and all four address entries from eng_addr (using the R6 packing), and it sets irq.
- R10: While BSY is set, host writes at selects 0, 1 and 2 have no effect. Writes at select 3 are still taken.
- R11: An accepted command write clears a pending irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 address low, 1 address high, 2 status/command, 3 alternate status/device control |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe (side effects only) |
| host_rdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Pending interrupt |
| cmd_start | output | 1 | One-cycle command start pulse |
| cmd_code | output | 8 | Latched command byte |
| cmd_addr | output | 32 | Address entries {prev hi, prev lo, cur hi, cur lo} |
| eng_done | input | 1 | Engine end-of-command strobe |
| eng_status | input | 8 | Status byte supplied at completion |
| eng_addr | input | 32 | Address contents supplied at completion, same packing as cmd_addr |

## Verification
The embedded assertions check several rules on every cycle: an alternate-status read never drops irq, a primary read does drop it, completion always raises it, and the start pulse never lasts two cycles. They also check that an accepted address write shifts current into previous and that writes taken while busy leave the address entries frozen. The bench scenarios are needed for the values themselves. These are what each select returns with the high-order bit set and clear, the command code and packed address seen at the start pulse, and the exact status byte after a command or a completion. The bench also exercises the ordering cases: completion and acknowledge in the same cycle, device-control writes while busy, and the clearing of the high-order bit by later writes.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int BYTE_W = 8;
  localparam int BSY_BIT = 7;
  localparam int HOB_BIT = 7;
  localparam logic [BYTE_W-1:0] STAT_RESET = 8'h40;

  typedef enum logic [1:0] {
    SEL_ALO  = 2'd0,
    SEL_AHI  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_ALT  = 2'd3
  } tf_sel_e;

  // Status after an accepted command: BSY forced, rest kept.
  function automatic logic [BYTE_W-1:0] with_busy(input logic [BYTE_W-1:0] s);
    logic [BYTE_W-1:0] r;
    r = s;
    r[BSY_BIT] = 1'b1;
    return r;
  endfunction

  // Address entries in engine order: LBA 47:40, 39:32, 23:16, 15:8.
  function automatic logic [4*BYTE_W-1:0] pack_addr(
    input logic [BYTE_W-1:0] cur_lo, input logic [BYTE_W-1:0] cur_hi,
    input logic [BYTE_W-1:0] prv_lo, input logic [BYTE_W-1:0] prv_hi);
    return {prv_hi, prv_lo, cur_hi, cur_lo};
  endfunction
endpackage

// File: rtl/tf_addr_slot.sv
module tf_addr_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [DW-1:0] host_d,
  input  logic          eng_we,
  input  logic [DW-1:0] eng_cur,
  input  logic [DW-1:0] eng_prv,
  output logic [DW-1:0] cur_q,
  output logic [DW-1:0] prv_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      prv_q <= '0;
    end else if (eng_we) begin
      cur_q <= eng_cur;
      prv_q <= eng_prv;
    end else if (host_we) begin
      prv_q <= cur_q;
      cur_q <= host_d;
    end
  end

  // R7: host write shifts current into previous
  a_r7_shift: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && !eng_we |=> (prv_q == $past(cur_q)) && (cur_q == $past(host_d)));

  // R9: completion loads both entries
  a_r9_eng_load: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |=> (cur_q == $past(eng_cur)) && (prv_q == $past(eng_prv)));
endmodule

// File: rtl/tf_status_irq.sv
module tf_status_irq
  import tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_accept,
  input  logic              stat_ack,
  input  logic              alt_rd,
  input  logic              eng_done,
  input  logic [BYTE_W-1:0] eng_status,
  output logic [BYTE_W-1:0] status_q,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STAT_RESET;
      irq_q    <= 1'b0;
    end else begin
      if (eng_done)        status_q <= eng_status;
      else if (cmd_accept) status_q <= with_busy(status_q);

      if (eng_done)                     irq_q <= 1'b1;
      else if (stat_ack || cmd_accept)  irq_q <= 1'b0;
    end
  end

  // R3: alternate read leaves a pending interrupt alone
  a_r3_alt_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && alt_rd && !stat_ack && !cmd_accept |=> irq_q);

  // R4: primary read acknowledges unless completion collides
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ack && !eng_done |=> !irq_q);

  // R9: completion raises the interrupt
  a_r9_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> irq_q && (status_q == $past(eng_status)));

  // R2: accepted command sets BSY
  a_r2_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && !eng_done |=> status_q[BSY_BIT]);
endmodule

// File: rtl/tf_regbank.sv
module tf_regbank
  import tf_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       host_sel,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_rd,
  output logic [DW-1:0]    host_rdata,
  output logic             irq,
  output logic             cmd_start,
  output logic [DW-1:0]    cmd_code,
  output logic [4*DW-1:0]  cmd_addr,
  input  logic             eng_done,
  input  logic [DW-1:0]    eng_status,
  input  logic [4*DW-1:0]  eng_addr
);
  localparam int NSLOT = 2;

  tf_sel_e     sel_e;
  logic [DW-1:0] status_q;
  logic        busy;
  logic        cmd_accept;
  logic        ctl_wr;
  logic        stat_ack;
  logic        alt_rd;
  logic        hob_q;
  logic [NSLOT-1:0] addr_we;
  logic [DW-1:0] cur_q [NSLOT];
  logic [DW-1:0] prv_q [NSLOT];

  assign sel_e      = tf_sel_e'(host_sel);
  assign busy       = status_q[BSY_BIT];
  assign cmd_accept = host_wr && (sel_e == SEL_STAT) && !busy;
  assign ctl_wr     = host_wr && (sel_e == SEL_ALT);
  assign stat_ack   = host_rd && (sel_e == SEL_STAT);
  assign alt_rd     = host_rd && (sel_e == SEL_ALT);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign addr_we[i] = host_wr && (host_sel == 2'(i)) && !busy;
    tf_addr_slot #(.DW(DW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .host_we (addr_we[i]),
      .host_d  (host_wdata),
      .eng_we  (eng_done),
      .eng_cur (eng_addr[i*DW +: DW]),
      .eng_prv (eng_addr[(NSLOT+i)*DW +: DW]),
      .cur_q   (cur_q[i]),
      .prv_q   (prv_q[i])
    );
  end

  tf_status_irq u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_accept (cmd_accept),
    .stat_ack   (stat_ack),
    .alt_rd     (alt_rd),
    .eng_done   (eng_done),
    .eng_status (eng_status),
    .status_q   (status_q),
    .irq_q      (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hob_q     <= 1'b0;
      cmd_start <= 1'b0;
      cmd_code  <= '0;
    end else begin
      if (ctl_wr)                         hob_q <= host_wdata[HOB_BIT];
      else if ((|addr_we) || cmd_accept)  hob_q <= 1'b0;
      cmd_start <= cmd_accept;
      if (cmd_accept) cmd_code <= host_wdata;
    end
  end

  assign cmd_addr = pack_addr(cur_q[0], cur_q[1], prv_q[0], prv_q[1]);

  always_comb begin
    unique case (sel_e)
      SEL_ALO: host_rdata = hob_q ? prv_q[0] : cur_q[0];
      SEL_AHI: host_rdata = hob_q ? prv_q[1] : cur_q[1];
      default: host_rdata = status_q;
    endcase
  end

  // R5: start pulse lasts one cycle
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  // R5: start pulse follows an accepted command write
  a_r5_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> cmd_start && (cmd_code == $past(host_wdata)));

  // R10: busy writes leave the address entries frozen
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && host_wr && (sel_e != SEL_ALT) && !eng_done |=> $stable(cmd_addr));

  // R8: accepted task-file write clears the high-order select
  a_r8_hob_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((|addr_we) || cmd_accept) |=> !hob_q);
endmodule

// File: tb/test_tf_regbank.sv
module test_tf_regbank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  host_sel = 0;
  logic        host_wr = 0;
  logic [7:0]  host_wdata = 0;
  logic        host_rd = 0;
  logic [7:0]  host_rdata;
  logic        irq, cmd_start;
  logic [7:0]  cmd_code;
  logic [31:0] cmd_addr;
  logic        eng_done = 0;
  logic [7:0]  eng_status = 0;
  logic [31:0] eng_addr = 0;

  int checks = 0, errors = 0;
  logic [7:0] m_clo, m_chi, m_plo, m_phi, m_stat;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  tf_regbank i_tf_regbank (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_rd = 1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic done(input logic [7:0] st, input logic [31:0] a);
    @(negedge clk);
    eng_done = 1; eng_status = st; eng_addr = a;
    @(negedge clk);
    eng_done = 0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2, rv); chk("R1 status", rv, 8'h40);
    chk("R1 irq", irq, 0); chk("R1 start", cmd_start, 0);
    chk("R1 addr", cmd_addr, 0);
    rd(0, rv); chk("R1 lo", rv, 0);
    m_clo = 0; m_chi = 0; m_plo = 0; m_phi = 0; m_stat = 8'h40;

    // R7 sweep of all byte values over both address bytes
    for (int v = 0; v < 256; v++) begin
      logic [1:0] s;
      s = 2'(v % 2);
      wr(s, 8'(v * 37 + 5));
      if (s == 0) begin m_plo = m_clo; m_clo = 8'(v * 37 + 5); end
      else        begin m_phi = m_chi; m_chi = 8'(v * 37 + 5); end
      chk("R7 shift", cmd_addr, {m_phi, m_plo, m_chi, m_clo});
    end
    rd(0, rv); chk("R7 lo read", rv, m_clo);
    rd(1, rv); chk("R7 hi read", rv, m_chi);

    // R8 high-order select
    wr(3, 8'h80);
    rd(0, rv); chk("R8 hob lo", rv, m_plo);
    rd(1, rv); chk("R8 hob hi", rv, m_phi);
    wr(1, 8'hC3); m_phi = m_chi; m_chi = 8'hC3;
    rd(1, rv); chk("R8 cleared by write", rv, m_chi);
    wr(3, 8'h7F);
    rd(0, rv); chk("R8 bit7 zero", rv, m_clo);

    // R5 R6 R2 command write
    wr(2, 8'h24);
    chk("R5 start high", cmd_start, 1);
    chk("R5 code", cmd_code, 8'h24);
    chk("R6 addr", cmd_addr, {m_phi, m_plo, m_chi, m_clo});
    @(negedge clk); chk("R5 start low", cmd_start, 0);
    rd(2, rv); chk("R2 busy set", rv, m_stat | 8'h80);

    // R10 writes ignored while busy, device control taken
    wr(0, 8'hEE); wr(1, 8'hDD); wr(2, 8'h99);
    chk("R10 no start", cmd_start, 0);
    chk("R10 addr frozen", cmd_addr, {m_phi, m_plo, m_chi, m_clo});
    chk("R10 code kept", cmd_code, 8'h24);
    wr(3, 8'h80);
    rd(0, rv); chk("R10 ctl taken", rv, m_plo);
    wr(3, 8'h00);

    // R9 completion
    done(8'h51, 32'hA1B2C3D4);
    m_stat = 8'h51; m_phi = 8'hA1; m_plo = 8'hB2; m_chi = 8'hC3; m_clo = 8'hD4;
    chk("R9 irq", irq, 1);
    chk("R9 addr", cmd_addr, 32'hA1B2C3D4);
    rd(3, rv); chk("R3 alt value", rv, 8'h51);
    chk("R3 irq kept", irq, 1);
    rd(2, rv); chk("R2 status value", rv, 8'h51);
    chk("R4 ack", irq, 0);

    // R4 ack colliding with completion
    done(8'h50, 32'h01020304);
    @(negedge clk);
    host_sel = 2; host_rd = 1; eng_done = 1; eng_status = 8'h58; eng_addr = 32'h11223344;
    @(negedge clk);
    host_rd = 0; eng_done = 0;
    chk("R4 collision irq", irq, 1);
    rd(3, rv); chk("R2 status exact", rv, 8'h58);

    // R11 command write clears irq; R2 keeps low bits
    wr(2, 8'hC8);
    chk("R11 irq cleared", irq, 0);
    rd(3, rv); chk("R2 busy keep bits", rv, 8'hD8);
    done(8'h40, 32'h0);
    rd(2, rv);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule